// File: doc/BRIEF.md
# Linear Burst Read Address Generator

This block produces the word address for a sequential burst read out of a memory array of 524,288 words, which takes a 19-bit word address. A host gives a starting address and pulses an active-low load strobe. The block captures that address on the next clock edge. After that, each clock edge on which the active-low advance strobe is low moves the address to the next word.

A burst is 32 words long and stays inside the aligned 32-word block that contains the start address. Only the five low address bits count. When they pass 31 they go back to 0, and the upper fourteen bits never change. A one-cycle wrap flag marks the rollover. A valid flag shows that an address has been loaded since reset. Both strobes are sampled only on rising edges of the dedicated clock. Reset is synchronous and active high.

Top module: `lbr_addr_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `burst_addr` = 0, `burst_valid` = 0 and `burst_wrap` = 0.
- R2: A rising edge with `load_n` low sets `burst_addr` to `start_addr` and sets `burst_valid` to 1.
- R3: A rising edge where `load_n` is high, `step_n` is low and `burst_valid` is 1 adds one, modulo 32, to `burst_addr[4:0]`.
- R4: A rising edge with `load_n` high never changes `burst_addr[18:5]`.
- R5: A step taken with `burst_addr[4:0]` = 31 gives `burst_addr[4:0]` = 0. `burst_wrap` is then 1 for exactly that one following cycle. `burst_wrap` is 0 after every other kind of edge.
- R6: A rising edge with both `load_n` and `step_n` high leaves `burst_addr` and `burst_valid` unchanged and clears `burst_wrap`.
- R7: When `load_n` and `step_n` are both low on the same edge, the load wins. The outputs become `start_addr` with `burst_wrap` = 0, and no increment happens.
- R8: Before the first load after reset, `step_n` low has no effect. `burst_addr` stays 0, and `burst_valid` and `burst_wrap` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock; every update is on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_n | input | 1 | Load strobe, active low; captures `start_addr` |
| step_n | input | 1 | Advance strobe, active low; moves to the next word |
| start_addr | input | 19 | Starting word address of the burst |
| burst_addr | output | 19 | Current word address |
| burst_valid | output | 1 | An address has been loaded since reset |
| burst_wrap | output | 1 | One-cycle pulse after the low five bits roll from 31 to 0 |

## Verification
Load and advance can both be requested on the same edge. That edge can also be the one on which the low bits sit at 31 and a wrap is about to happen. The bench first steps a burst up to offset 31. It then drives both strobes low together, and it repeats the pairing with many random strobe patterns. An edge with both strobes low is judged correct only if the new start address appears unchanged and no wrap pulse follows. A second directed case strobes advance before any load and checks that the outputs stay at their reset values.

// File: rtl/lbr_pkg.sv
package lbr_pkg;

    // Operation chosen for one clock edge; load outranks step.
    typedef enum logic [1:0] {
        LBR_HOLD = 2'd0,
        LBR_LOAD = 2'd1,
        LBR_STEP = 2'd2
    } lbr_op_e;

    // Status flags that travel together at the block's output.
    typedef struct packed {
        logic valid;
        logic wrap;
    } lbr_flags_t;

    // Priority decode of the two active-low strobes.
    function automatic lbr_op_e lbr_pick_op(input logic load_n,
                                            input logic step_n,
                                            input logic running);
        lbr_op_e op;
        if (!load_n)
            op = LBR_LOAD;
        else if (!step_n && running)
            op = LBR_STEP;
        else
            op = LBR_HOLD;
        return op;
    endfunction

endpackage

// File: rtl/lbr_cmd_decode.sv
module lbr_cmd_decode
    import lbr_pkg::*;
(
    input  logic    load_n,
    input  logic    step_n,
    input  logic    running,
    output lbr_op_e op
);

    always_comb begin
        op = lbr_pick_op(load_n, step_n, running);
    end

    // R7: a load strobe always yields a load; R8: no step while idle.
    always_comb begin
        a_r7_load_first: assert (load_n || op == LBR_LOAD);
        a_r8_no_idle_step: assert (running || op != LBR_STEP);
    end

endmodule

// File: rtl/lbr_base_reg.sv
module lbr_base_reg
    import lbr_pkg::*;
#(
    parameter int BASE_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  lbr_op_e           op,
    input  logic [BASE_W-1:0] base_in,
    output logic [BASE_W-1:0] base_q
);

    always_ff @(posedge clk) begin
        if (rst)
            base_q <= '0;
        else if (op == LBR_LOAD)
            base_q <= base_in;
    end

    // R4: the window base only moves on a load.
    a_r4_base_frozen: assert property (@(posedge clk) disable iff (rst)
        (op != LBR_LOAD) |=> (base_q == $past(base_q)));

endmodule

// File: rtl/lbr_offset_ctr.sv
module lbr_offset_ctr
    import lbr_pkg::*;
#(
    parameter int OFS_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  lbr_op_e          op,
    input  logic [OFS_W-1:0] ofs_in,
    output logic [OFS_W-1:0] ofs_q,
    output logic             wrap_q
);

    localparam logic [OFS_W-1:0] OFS_LAST = {OFS_W{1'b1}};

    logic [OFS_W-1:0] ofs_next;
    logic             wrap_next;

    always_comb begin
        ofs_next  = ofs_q;
        wrap_next = 1'b0;
        unique case (op)
            LBR_LOAD: ofs_next = ofs_in;
            LBR_STEP: begin
                ofs_next  = ofs_q + OFS_W'(1);
                wrap_next = (ofs_q == OFS_LAST);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ofs_q  <= '0;
            wrap_q <= 1'b0;
        end else begin
            ofs_q  <= ofs_next;
            wrap_q <= wrap_next;
        end
    end

    // R3: a step moves the offset by one, modulo the window.
    a_r3_step_by_one: assert property (@(posedge clk) disable iff (rst)
        (op == LBR_STEP) |=> (ofs_q == $past(ofs_q) + OFS_W'(1)));

    // R5: a wrap pulse only ever lands on offset zero and lasts one cycle.
    a_r5_wrap_at_zero: assert property (@(posedge clk) disable iff (rst)
        wrap_q |-> (ofs_q == '0));
    a_r5_wrap_single: assert property (@(posedge clk) disable iff (rst)
        wrap_q && (op != LBR_STEP) |=> !wrap_q);

endmodule

// File: rtl/lbr_addr_gen.sv
module lbr_addr_gen
    import lbr_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int BURST_LEN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_n,
    input  logic              step_n,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] burst_addr,
    output logic              burst_valid,
    output logic              burst_wrap
);

    localparam int OFS_W  = $clog2(BURST_LEN);
    localparam int BASE_W = ADDR_W - OFS_W;

    lbr_op_e            op;
    lbr_flags_t         flags;
    logic [BASE_W-1:0]  base_q;
    logic [OFS_W-1:0]   ofs_q;
    logic               valid_q;
    logic               wrap_q;

    lbr_cmd_decode u_dec (
        .load_n  (load_n),
        .step_n  (step_n),
        .running (valid_q),
        .op      (op)
    );

    lbr_base_reg #(.BASE_W(BASE_W)) u_base (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .base_in (start_addr[ADDR_W-1:OFS_W]),
        .base_q  (base_q)
    );

    lbr_offset_ctr #(.OFS_W(OFS_W)) u_ofs (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .ofs_in (start_addr[OFS_W-1:0]),
        .ofs_q  (ofs_q),
        .wrap_q (wrap_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            valid_q <= 1'b0;
        else if (op == LBR_LOAD)
            valid_q <= 1'b1;
    end

    always_comb begin
        flags.valid = valid_q;
        flags.wrap  = wrap_q;
    end

    assign burst_addr  = {base_q, ofs_q};
    assign burst_valid = flags.valid;
    assign burst_wrap  = flags.wrap;

    // R1: reset clears every output.
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (burst_addr == '0 && !burst_valid && !burst_wrap));

    // R2: a load presents the start address, valid, on the next cycle.
    a_r2_load_capture: assert property (@(posedge clk) disable iff (rst)
        !load_n |=> (burst_addr == $past(start_addr) && burst_valid));

    // R7: load beats advance and never produces a wrap pulse.
    a_r7_load_beats_step: assert property (@(posedge clk) disable iff (rst)
        (!load_n && !step_n) |=> (burst_addr == $past(start_addr) && !burst_wrap));

    // R6: with both strobes idle everything holds and no wrap shows.
    a_r6_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (load_n && step_n) |=> ($stable(burst_addr) && $stable(burst_valid) && !burst_wrap));

    // R8: advance before any load leaves the reset state alone.
    a_r8_idle_ignore: assert property (@(posedge clk) disable iff (rst)
        (load_n && !burst_valid) |=> (!burst_valid && burst_addr == '0 && !burst_wrap));

endmodule

// File: tb/lbr_addr_gen_tb.sv
`timescale 1ns/1ps
module lbr_addr_gen_tb_top;

    localparam int AW = 19;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          load_n = 1'b1;
    logic          step_n = 1'b1;
    logic [AW-1:0] start_addr = '0;
    logic [AW-1:0] burst_addr;
    logic          burst_valid;
    logic          burst_wrap;

    int n_checks = 0;
    int n_fails  = 0;

    // Reference state built from the requirements.
    logic [AW-1:0] m_addr  = '0;
    logic          m_valid = 1'b0;
    logic          m_wrap  = 1'b0;

    always #4 clk = ~clk;

    lbr_addr_gen dut_i (
        .clk         (clk),
        .rst         (rst),
        .load_n      (load_n),
        .step_n      (step_n),
        .start_addr  (start_addr),
        .burst_addr  (burst_addr),
        .burst_valid (burst_valid),
        .burst_wrap  (burst_wrap)
    );

    function automatic logic [AW+1:0] model_next(input logic [AW-1:0] a, input logic v,
                                                 input logic r, input logic ld, input logic st,
                                                 input logic [AW-1:0] sa);
        logic [AW-1:0] na;
        logic          nv;
        logic          nw;
        na = a; nv = v; nw = 1'b0;
        if (r) begin
            na = '0; nv = 1'b0;
        end else if (!ld) begin
            na = sa; nv = 1'b1;
        end else if (!st && v) begin
            nw = (a[4:0] == 5'd31);
            na = {a[AW-1:5], a[4:0] + 5'd1};
        end
        return {na, nv, nw};
    endfunction

    function automatic string req_of(input logic r, input logic ld, input logic st, input logic v);
        if (r) return "R1";
        if (!ld && !st) return "R7";
        if (!ld) return "R2";
        if (!st && !v) return "R8";
        if (!st) return "R3/R4/R5";
        return "R6";
    endfunction

    task automatic check(input string req);
        n_checks++;
        if ({burst_addr, burst_valid, burst_wrap} !== {m_addr, m_valid, m_wrap}) begin
            n_fails++;
            $display("FAIL %s: addr=%h valid=%b wrap=%b expected addr=%h valid=%b wrap=%b",
                     req, burst_addr, burst_valid, burst_wrap, m_addr, m_valid, m_wrap);
        end
    endtask

    // Drive at a falling edge, let one rising edge act, check at the next falling edge.
    task automatic cycle(input logic r, input logic ld, input logic st, input logic [AW-1:0] sa,
                         input string req);
        rst = r; load_n = ld; step_n = st; start_addr = sa;
        @(posedge clk);
        {m_addr, m_valid, m_wrap} = model_next(m_addr, m_valid, r, ld, st, sa);
        @(negedge clk);
        check(req);
    endtask

    initial begin
        #(8 * 200000);
        n_fails++;
        n_checks++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20061));
        @(negedge clk);
        cycle(1'b1, 1'b1, 1'b1, '0, "R1");           // R1 reset state
        cycle(1'b0, 1'b1, 1'b0, 19'h7FFFF, "R8");     // R8 step before load
        cycle(1'b0, 1'b1, 1'b0, 19'h12345, "R8");
        cycle(1'b0, 1'b0, 1'b1, 19'h5A3FC, "R2");     // R2 load, offset 28
        for (int i = 0; i < 3; i++)
            cycle(1'b0, 1'b1, 1'b0, '0, "R3");       // R3 to offset 31
        cycle(1'b0, 1'b1, 1'b1, '0, "R6");            // R6 hold at 31
        cycle(1'b0, 1'b1, 1'b0, '0, "R5");            // R5 roll to 0, wrap pulse, R4 base kept
        cycle(1'b0, 1'b1, 1'b1, '0, "R5");            // R5 wrap lasts one cycle
        for (int i = 0; i < 31; i++)
            cycle(1'b0, 1'b1, 1'b0, '0, "R4");       // R4 base unchanged to offset 31
        cycle(1'b0, 1'b0, 1'b0, 19'h00021, "R7");     // R7 both strobes at offset 31
        cycle(1'b0, 1'b0, 1'b1, 19'h7FFFF, "R2");     // top of space
        cycle(1'b0, 1'b1, 1'b0, '0, "R5");            // wraps to 0x7FFE0
        cycle(1'b1, 1'b1, 1'b0, '0, "R1");
        for (int i = 0; i < 3000; i++) begin
            logic r, ld, st;
            logic [AW-1:0] sa;
            r  = ($urandom % 64) == 0;
            ld = ($urandom % 8) != 0;
            st = ($urandom % 4) == 0;
            sa = AW'($urandom);
            if (($urandom % 4) == 0) sa[4:0] = 5'd30 + 5'($urandom % 2);
            cycle(r, ld, st, sa, req_of(r, ld, st, m_valid));
        end
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule